// File: doc/BRIEF.md
# Banked GPIO and Pin-Mux Register File

This block holds the pin configuration behind a serial register front end for a mixed-signal monitor with 32 multi-purpose pins. Each pin acts as an analog converter input, a general-purpose input or a general-purpose output. The role of each pin comes from two enable bit-sets, one for input and one for output. A further bit-set holds the output levels. All of these are reached through a single byte-wide register port, and each 8-bit register covers one bank of 8 pins.

The pin levels pass through a two-stage synchroniser. The synchronised levels can be read through a read-only register group and are also available as a vector. The block drives three per-pin vectors toward the pads and the converter path: an output-enable, an output level, and an "acts as GPIO" flag that the converter path uses to mark a conversion result as taken from a digital pin. The serial protocol and the analog path sit outside this block.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset every input-enable, output-enable and output-value bit is 0, so all pins are analog inputs: `pin_oe`, `pin_out`, `pin_is_gpio` and `reg_rdata` are all zero.
- R2: The IO space uses 16 byte addresses. Offsets 0x0-0x3 hold input levels, 0x4-0x7 input enables, 0x8-0xB output enables and 0xC-0xF output levels. A write to an enable or output-level address is read back unchanged from the same address.
- R3: Within each group of four addresses, pins 0-7 sit at the highest address and each higher bank of 8 pins sits one address lower (for example, output levels of pins 24-31 are at 0xC). A pin's bit inside its byte is the pin number modulo 8.
- R4: A pin whose output-enable bit is 1 is an output: `pin_oe` is 1 and `pin_out` equals its output-level bit. For any other pin, `pin_oe` and `pin_out` are 0.
- R5: `pin_is_gpio` of a pin is 1 exactly when its input-enable or output-enable bit is 1. It is 0 only for an analog pin.
- R6: The input-level addresses are read-only. A write there changes no register and no output.
- R7: A change on `pin_in` appears on `pin_in_sync` and in the input-level registers after exactly two clock edges.
- R8: When both enable bits of a pin are 1, the pin acts as an output, and its input-level bit still reports the synchronised pin level.
- R9: A read of an address at 0x10 or above returns 0. A write to such an address changes nothing.
- R10: `reg_rdata` is loaded at the clock edge where `reg_rd_en` is 1 and holds its value while `reg_rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W (6) | Byte register address |
| reg_wr_en | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | BANK_W (8) | Write data |
| reg_rd_en | input | 1 | Read strobe; loads `reg_rdata` |
| reg_rdata | output | BANK_W (8) | Registered read data |
| pin_in | input | NUM_BANKS*BANK_W (32) | Raw pin levels |
| pin_in_sync | output | NUM_BANKS*BANK_W (32) | Synchronised pin levels |
| pin_oe | output | NUM_BANKS*BANK_W (32) | Per-pin output enable |
| pin_out | output | NUM_BANKS*BANK_W (32) | Per-pin driven level, 0 when not an output |
| pin_is_gpio | output | NUM_BANKS*BANK_W (32) | Per-pin digital-role flag for the converter status |

## Verification
The bench builds the block with its default parameters: 4 banks of 8 pins and a 6-bit address. At that size every one of the 64 addresses can be swept, including the 48 out-of-range ones. All 32 pins can also be taken through all four combinations of their two enable bits. A walking-one pattern on the pin inputs checks the bank-reversed placement and the two-edge synchroniser delay for every pin. The expected register and pin values come from a bench model of the address arithmetic.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    // Register group, taken from the two address bits above the bank slot
    typedef enum logic [1:0] {
        GRP_IN_VAL  = 2'd0,
        GRP_IN_EN   = 2'd1,
        GRP_OUT_EN  = 2'd2,
        GRP_OUT_VAL = 2'd3
    } reg_group_e;

    // Resolved pin role
    typedef enum logic [1:0] {
        ROLE_ANALOG = 2'd0,
        ROLE_INPUT  = 2'd1,
        ROLE_OUTPUT = 2'd2
    } pin_role_e;

endpackage

// File: rtl/gpio_mux_decode.sv
module gpio_mux_decode
    import gpio_mux_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_BANKS = 4,
    localparam int SLOT_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_group_e        group,
    output logic [SLOT_W-1:0] bank
);
    localparam int                IO_REGS  = 4 * NUM_BANKS;
    localparam logic [ADDR_W-1:0] IO_LIMIT = ADDR_W'(IO_REGS);

    logic [SLOT_W-1:0] slot;

    always_comb begin
        hit   = (addr < IO_LIMIT);
        group = reg_group_e'(addr[SLOT_W+1:SLOT_W]);
        slot  = addr[SLOT_W-1:0];
        // Lowest pin bank at the highest slot of each group
        bank  = SLOT_W'(NUM_BANKS - 1) - slot;
    end

endmodule

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_out = s_q.stable;

endmodule

// File: rtl/gpio_mux_role.sv
module gpio_mux_role
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] in_en,
    input  logic [NUM_PINS-1:0] out_en,
    input  logic [NUM_PINS-1:0] out_lvl,
    output logic [NUM_PINS-1:0] oe,
    output logic [NUM_PINS-1:0] drive,
    output logic [NUM_PINS-1:0] is_gpio
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_role_e role;

        always_comb begin
            if (out_en[p]) begin
                role = ROLE_OUTPUT;
            end else if (in_en[p]) begin
                role = ROLE_INPUT;
            end else begin
                role = ROLE_ANALOG;
            end
        end

        assign oe[p]      = (role == ROLE_OUTPUT);
        assign is_gpio[p] = (role != ROLE_ANALOG);
        assign drive[p]   = (role == ROLE_OUTPUT) & out_lvl[p];
    end

endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
    import gpio_mux_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_wr_en,
    input  logic [BANK_W-1:0]             reg_wdata,
    input  logic                          reg_rd_en,
    output logic [BANK_W-1:0]             reg_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   pin_in,
    output logic [NUM_BANKS*BANK_W-1:0]   pin_in_sync,
    output logic [NUM_BANKS*BANK_W-1:0]   pin_oe,
    output logic [NUM_BANKS*BANK_W-1:0]   pin_out,
    output logic [NUM_BANKS*BANK_W-1:0]   pin_is_gpio
);
    localparam int NUM_PINS = NUM_BANKS * BANK_W;
    localparam int SLOT_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    typedef struct packed {
        logic [NUM_PINS-1:0] in_en;
        logic [NUM_PINS-1:0] out_en;
        logic [NUM_PINS-1:0] out_lvl;
        logic [BANK_W-1:0]   rdata;
    } state_t;

    state_t st_d, st_q;

    logic              dec_hit;
    reg_group_e        dec_group;
    logic [SLOT_W-1:0] dec_bank;
    logic [BANK_W-1:0] rd_pick;
    logic [NUM_PINS-1:0] lvl_sync;

    gpio_mux_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_decode (
        .addr  (reg_addr),
        .hit   (dec_hit),
        .group (dec_group),
        .bank  (dec_bank)
    );

    gpio_mux_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl_sync)
    );

    always_comb begin
        st_d    = st_q;
        rd_pick = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec_bank == SLOT_W'(b)) begin
                unique case (dec_group)
                    GRP_IN_VAL:  rd_pick = lvl_sync[b*BANK_W +: BANK_W];
                    GRP_IN_EN:   rd_pick = st_q.in_en[b*BANK_W +: BANK_W];
                    GRP_OUT_EN:  rd_pick = st_q.out_en[b*BANK_W +: BANK_W];
                    GRP_OUT_VAL: rd_pick = st_q.out_lvl[b*BANK_W +: BANK_W];
                endcase
                if (reg_wr_en && dec_hit) begin
                    case (dec_group)
                        GRP_IN_EN:   st_d.in_en[b*BANK_W +: BANK_W]   = reg_wdata;
                        GRP_OUT_EN:  st_d.out_en[b*BANK_W +: BANK_W]  = reg_wdata;
                        GRP_OUT_VAL: st_d.out_lvl[b*BANK_W +: BANK_W] = reg_wdata;
                        default: ; // level group is read-only
                    endcase
                end
            end
        end
        if (reg_rd_en) begin
            st_d.rdata = dec_hit ? rd_pick : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    gpio_mux_role #(
        .NUM_PINS (NUM_PINS)
    ) u_role (
        .in_en   (st_q.in_en),
        .out_en  (st_q.out_en),
        .out_lvl (st_q.out_lvl),
        .oe      (pin_oe),
        .drive   (pin_out),
        .is_gpio (pin_is_gpio)
    );

    assign reg_rdata   = st_q.rdata;
    assign pin_in_sync = lvl_sync;

endmodule

// File: rtl/gpio_mux_bank_chk.sv
module gpio_mux_bank_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic                        reg_wr_en,
    input logic                        reg_rd_en,
    input logic [BANK_W-1:0]           reg_rdata,
    input logic [NUM_BANKS*BANK_W-1:0] pin_in,
    input logic [NUM_BANKS*BANK_W-1:0] pin_in_sync,
    input logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    input logic [NUM_BANKS*BANK_W-1:0] pin_out,
    input logic [NUM_BANKS*BANK_W-1:0] pin_is_gpio
);
    localparam logic [ADDR_W-1:0] IO_LIMIT = ADDR_W'(4 * NUM_BANKS);
    localparam logic [ADDR_W-1:0] RO_LIMIT = ADDR_W'(NUM_BANKS);

    logic [1:0] settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= 2'd0;
        end else if (settle_q != 2'd3) begin
            settle_q <= settle_q + 2'd1;
        end
    end

    AST_OE_IS_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~pin_is_gpio) == '0); // R5

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0); // R4

    AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr < RO_LIMIT)
        |=> ($stable(pin_oe) && $stable(pin_out) && $stable(pin_is_gpio))); // R6

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr >= IO_LIMIT) |=> (reg_rdata == '0)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata)); // R10

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q >= 2'd2) |-> (pin_in_sync == $past(pin_in, 2))); // R7

endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_rdata   (reg_rdata),
    .pin_in      (pin_in),
    .pin_in_sync (pin_in_sync),
    .pin_oe      (pin_oe),
    .pin_out     (pin_out),
    .pin_is_gpio (pin_is_gpio)
);

// File: tb/gpio_mux_bank_bench.sv
module gpio_mux_bank_bench;
    localparam int NB = 4;
    localparam int BW = 8;
    localparam int AW = 6;
    localparam int NP = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [BW-1:0] reg_wdata = '0;
    logic          reg_rd_en = 1'b0;
    logic [BW-1:0] reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_in_sync, pin_oe, pin_out, pin_is_gpio;

    gpio_mux_bank #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(AW)) u_gpio_mux_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_in_sync(pin_in_sync), .pin_oe(pin_oe),
        .pin_out(pin_out), .pin_is_gpio(pin_is_gpio)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [NP-1:0] m_ien = '0, m_oen = '0, m_oval = '0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(int grp, int bank);
        return AW'(grp * NB + (NB - 1 - bank));
    endfunction

    function automatic logic [BW-1:0] model_read(int a);
        int g, b;
        if (a >= 4 * NB) return '0;
        g = a / NB;
        b = NB - 1 - (a % NB);
        case (g)
            0: return pin_in[b*BW +: BW];
            1: return m_ien[b*BW +: BW];
            2: return m_oen[b*BW +: BW];
            default: return m_oval[b*BW +: BW];
        endcase
    endfunction

    task automatic bus_write(input int a, input logic [BW-1:0] d);
        int g, b;
        @(negedge clk);
        reg_addr = AW'(a); reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a < 4 * NB) begin
            g = a / NB;
            b = NB - 1 - (a % NB);
            case (g)
                1: m_ien[b*BW +: BW] = d;
                2: m_oen[b*BW +: BW] = d;
                3: m_oval[b*BW +: BW] = d;
                default: ;
            endcase
        end
    endtask

    task automatic bus_read(input int a, output logic [BW-1:0] d);
        @(negedge clk);
        reg_addr = AW'(a); reg_rd_en = 1'b1;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic check_pins(input string req);
        check(req, "pin_oe", pin_oe, m_oen);
        check(req, "pin_is_gpio", pin_is_gpio, m_oen | m_ien);
        check(req, "pin_out", pin_out, m_oval & m_oen);
    endtask

    task automatic check_reads(input string req);
        logic [BW-1:0] d;
        for (int a = 0; a < 4 * NB; a++) begin
            bus_read(a, d);
            check(req, $sformatf("read addr %0d", a), 32'(d), 32'(model_read(a)));
        end
    endtask

    task automatic clear_all();
        for (int a = NB; a < 4 * NB; a++) bus_write(a, '0);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        logic [BW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "pin_oe", pin_oe, '0);
        check("R1", "pin_out", pin_out, '0);
        check("R1", "pin_is_gpio", pin_is_gpio, '0);
        check("R1", "reg_rdata", 32'(reg_rdata), 0);
        check_reads("R1");

        // R2, R3: distinct byte in every writable address, readback and pin mapping
        for (int g = 1; g < 4; g++) begin
            for (int b = 0; b < NB; b++) begin
                bus_write(addr_of(g, b), BW'(8'h5A ^ (g * 37 + b * 11)));
                check_pins("R3");
            end
        end
        check_reads("R2");

        // R4, R5, R8: every pin through every enable combination
        clear_all();
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 4; c++) begin
                logic [BW-1:0] bit_m;
                bit_m = BW'(1) << (p % BW);
                bus_write(addr_of(1, p / BW), c[0] ? bit_m : '0);
                bus_write(addr_of(2, p / BW), c[1] ? bit_m : '0);
                bus_write(addr_of(3, p / BW), bit_m);
                check_pins(c == 3 ? "R8" : "R4");
            end
            clear_all();
        end

        // R6: writes to the level group are ignored
        bus_write(addr_of(1, 2), 8'h3C);
        bus_write(addr_of(2, 1), 8'hC3);
        bus_write(addr_of(3, 1), 8'hFF);
        for (int a = 0; a < NB; a++) begin
            bus_write(a, 8'hFF);
            check_pins("R6");
        end
        check_reads("R6");

        // R7: walking one, two-edge delay and bank placement
        for (int p = 0; p < NP; p++) begin
            logic [NP-1:0] prev;
            prev = pin_in;
            @(negedge clk);
            pin_in = NP'(1) << p;
            @(negedge clk);
            check("R7", "pin_in_sync after one edge", pin_in_sync, prev);
            @(negedge clk);
            check("R7", "pin_in_sync after two edges", pin_in_sync, pin_in);
            bus_read(addr_of(0, p / BW), d);
            check("R7", "level readback", 32'(d), 32'(BW'(1) << (p % BW)));
        end

        // R8: both enables set, level still reported
        bus_write(addr_of(1, 0), 8'hFF);
        bus_write(addr_of(2, 0), 8'hFF);
        bus_write(addr_of(3, 0), 8'h00);
        @(negedge clk);
        pin_in = 32'h0000_00A5;
        repeat (3) @(negedge clk);
        check_pins("R8");
        bus_read(addr_of(0, 0), d);
        check("R8", "level with both enables", 32'(d), 32'hA5);

        // R9: out-of-range addresses
        for (int a = 4 * NB; a < (1 << AW); a++) begin
            bus_read(addr_of(0, 0), d);
            bus_write(a, 8'hFF);
            bus_read(a, d);
            check("R9", $sformatf("read addr %0d", a), 32'(d), 0);
        end
        check_pins("R9");
        check_reads("R9");

        // R10: read data holds without a strobe
        bus_read(addr_of(2, 0), d);
        check("R10", "loaded", 32'(d), 32'hFF);
        bus_write(addr_of(2, 0), 8'h12);
        repeat (3) @(negedge clk);
        check("R10", "held", 32'(reg_rdata), 32'hFF);
        bus_read(addr_of(2, 0), d);
        check("R10", "reloaded", 32'(d), 32'h12);

        done = 1;
        report();
    end

endmodule